// File: doc/BRIEF.md
# Frequency-Change Watchdog Recovery Controller

This block guards a run-time change of the system clock frequency. Software loads a timeout in half-second units, a fallback choice bit and then a new frequency selection. It can select either a software frequency code or the programmable divider mode. If the timeout field is non-zero, that selection write starts a countdown. When the changed clock runs correctly, software writes zero to the timeout field before the countdown ends, and the new frequency stays in place.

If the countdown runs out, the system has probably hung. The block then drives an active-low reset pulse of fixed length and sets a sticky timeout flag. It also picks the frequency to use after the reset: the hardware-latched code when the fallback bit is 0, or the software code when it is 1.

A prescaler derives both time bases from the core clock. The clocks per half-second unit and the clocks per reset pulse are parameters, so a fast simulation can use small values.

Top module: `fcw_recovery`

## Requirements
- R1: After reset, `sys_rst_n` is 1, `wd_timeout` is 0, `div_mode` is 0 and `freq_code` equals `hw_code`.
- R2: A write to address 1 loads `wr_data[4:0]` as the software code, and `freq_code` shows it from the cycle after the write. A write to address 2 sets `div_mode` to `wr_data[0]` from the cycle after the write.
- R3: Address 0 holds the timeout in half-second units (`wr_data[3:0]`) and the fallback bit (`wr_data[4]`). The countdown starts only on a write to address 1, or a write to address 2 with bit 0 set, while the stored timeout is non-zero. With a zero timeout, `sys_rst_n` never falls.
- R4: With no further write, `sys_rst_n` goes low exactly timeout × `TICK_DIV` clock cycles after the edge that took the arming write.
- R5: `sys_rst_n` stays low for exactly `PULSE_CYC` cycles and then returns to 1.
- R6: `wd_timeout` becomes 1 in the same cycle that `sys_rst_n` goes low.
- R7: On expiry with the fallback bit at 0, `freq_code` returns to `hw_code` and `div_mode` clears.
- R8: On expiry with the fallback bit at 1, `freq_code` keeps the software code and `div_mode` keeps its value.
- R9: `wd_timeout` stays at 1 until reset or a write to address 0 with bit 7 set, which clears it.
- R10: A write of 0 to the timeout field of address 0 while the countdown runs cancels it. No reset pulse follows, and the software selection stays in effect.
- R11: An arming write while the countdown already runs restarts it from the stored timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_code | input | 5 | Frequency code latched by hardware at power-up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 timeout, 1 software code, 2 divider mode |
| wr_data | input | 8 | Register write data |
| freq_code | output | 5 | Frequency code now in use |
| div_mode | output | 1 | Programmable divider mode active |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wd_timeout | output | 1 | Sticky flag: the watchdog has expired |

## Verification
The prescaler and the half-unit counter are the hidden state. If either is off by one, the falling edge of `sys_rst_n` moves by a cycle or by a whole `TICK_DIV`, so the bench samples that edge on the exact cycle expected. If the armed state is wrong, a spurious or missing pulse shows up within one timeout window after a zero-timeout or cancelled change. A wrong fallback decision is visible on `freq_code` and `div_mode` on the very cycle the reset pulse starts.

// File: rtl/fcw_pkg.sv
// Package: register addresses and field positions shared by the
// frequency-change watchdog recovery blocks.
package fcw_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int CODE_W = 5;
    localparam int HALF_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_WDOG = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FSEL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd2;

    localparam int BIT_REVERT = 4;
    localparam int BIT_CLEAR  = 7;
    localparam int BIT_DIVEN  = 0;

    typedef struct packed {
        logic [HALF_W-1:0] halves;
        logic              revert;
    } wdog_cfg_t;
endpackage

// File: rtl/fcw_regs.sv
// Module: fcw_regs
// Holds the timeout field, the fallback bit and the software code.
// Decodes writes into arm, cancel, divider and status-clear strobes.
// Assumes one write per cycle. The arm test uses the timeout value
// already stored, not the data of the same write.
module fcw_regs
    import fcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wdog_cfg_t         cfg,
    output logic [CODE_W-1:0] sw_code,
    output logic              sw_wr,
    output logic              div_set,
    output logic              div_clr,
    output logic              arm,
    output logic              cancel,
    output logic              clr_status
);
    logic wr_wdog, wr_fsel, wr_div;
    logic unused_bits;

    // Decode the targeted register.
    always_comb begin
        wr_wdog = wr_en && (wr_addr == ADDR_WDOG);
        wr_fsel = wr_en && (wr_addr == ADDR_FSEL);
        wr_div  = wr_en && (wr_addr == ADDR_DIV);
    end

    assign unused_bits = &{1'b0, wr_data[6:5]};

    // Derive the strobes used by the countdown and selection logic.
    always_comb begin
        sw_wr      = wr_fsel;
        div_set    = wr_div && wr_data[BIT_DIVEN];
        div_clr    = wr_div && !wr_data[BIT_DIVEN];
        arm        = (wr_fsel || div_set) && (cfg.halves != '0);
        cancel     = wr_wdog && (wr_data[HALF_W-1:0] == '0);
        clr_status = wr_wdog && wr_data[BIT_CLEAR];
    end

    // Store the configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            sw_code <= '0;
        end else begin
            if (wr_wdog) begin
                cfg.halves <= wr_data[HALF_W-1:0];
                cfg.revert <= wr_data[BIT_REVERT];
            end
            if (wr_fsel) begin
                sw_code <= wr_data[CODE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/fcw_wdog.sv
// Module: fcw_wdog
// Countdown in half-second units. A prescaler divides the core clock
// by TICK_DIV. The count restarts on arm and stops on cancel.
// expire is a one-cycle pulse in the last cycle of the timeout.
// Assumes halves is non-zero whenever arm is asserted.
module fcw_wdog #(
    parameter int TICK_DIV = 50_000_000,
    parameter int HALF_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              cancel,
    input  logic [HALF_W-1:0] halves,
    output logic              running,
    output logic              expire
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0]     pre;
    logic [HALF_W-1:0] rem;
    logic              tick_last;

    // Flag the last core cycle of each half-second unit, and the end of the timeout.
    always_comb begin
        tick_last = (pre == PRE_LAST);
        expire    = running && tick_last && (rem == HALF_W'(1));
    end

    // Step the prescaler and the remaining-unit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pre     <= '0;
            rem     <= '0;
        end else if (arm) begin
            running <= 1'b1;
            pre     <= '0;
            rem     <= halves;
        end else if (cancel) begin
            running <= 1'b0;
            pre     <= '0;
        end else if (running) begin
            if (tick_last) begin
                pre <= '0;
                rem <= rem - HALF_W'(1);
                if (rem == HALF_W'(1)) begin
                    running <= 1'b0;
                end
            end else begin
                pre <= pre + PW'(1);
            end
        end
    end
endmodule

// File: rtl/fcw_pulse.sv
// Module: fcw_pulse
// Drives the active-low system reset for PULSE_CYC cycles after expire,
// and keeps the sticky timeout flag. Assumes PULSE_CYC >= 1.
// When expire and clear come in the same cycle, the flag is set.
module fcw_pulse #(
    parameter int PULSE_CYC = 600_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_status,
    output logic sys_rst_n,
    output logic timeout_flag
);
    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC - 1);

    logic [CW-1:0] cnt;

    // Time the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst_n <= 1'b1;
            cnt       <= '0;
        end else if (expire) begin
            sys_rst_n <= 1'b0;
            cnt       <= CNT_LOAD;
        end else if (!sys_rst_n) begin
            if (cnt == '0) begin
                sys_rst_n <= 1'b1;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // Hold the sticky timeout status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_flag <= 1'b0;
        end else if (expire) begin
            timeout_flag <= 1'b1;
        end else if (clr_status) begin
            timeout_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/fcw_sel.sv
// Module: fcw_sel
// Chooses the frequency code and divider mode in use. Software writes
// switch to the programmed values. On expiry, the fallback bit picks
// the hardware-latched or the software source. Expiry wins over a write
// in the same cycle.
module fcw_sel #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] hw_code,
    input  logic [CODE_W-1:0] sw_code,
    input  logic              sw_wr,
    input  logic              div_set,
    input  logic              div_clr,
    input  logic              expire,
    input  logic              revert,
    output logic [CODE_W-1:0] freq_code,
    output logic              div_mode
);
    logic sw_on;

    // Track which source is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_on    <= 1'b0;
            div_mode <= 1'b0;
        end else if (expire) begin
            sw_on <= revert;
            if (!revert) begin
                div_mode <= 1'b0;
            end
        end else begin
            if (sw_wr) begin
                sw_on <= 1'b1;
            end
            if (div_set) begin
                div_mode <= 1'b1;
            end else if (div_clr) begin
                div_mode <= 1'b0;
            end
        end
    end

    // Select the code driven to the clock generator.
    always_comb begin
        freq_code = sw_on ? sw_code : hw_code;
    end
endmodule

// File: rtl/fcw_recovery.sv
// Module: fcw_recovery (top)
// Frequency-change watchdog recovery controller. It joins the register
// decode, the countdown, the reset pulse and the source selection.
// Assumes PULSE_CYC < TICK_DIV, so a pulse ends before another expiry.
module fcw_recovery
    import fcw_pkg::*;
#(
    parameter int TICK_DIV  = 50_000_000,
    parameter int PULSE_CYC = 600_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] hw_code,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] freq_code,
    output logic              div_mode,
    output logic              sys_rst_n,
    output logic              wd_timeout
);
    wdog_cfg_t         cfg;
    logic [CODE_W-1:0] sw_code;
    logic              sw_wr, div_set, div_clr, arm, cancel, clr_status;
    logic              wd_run, expire, revert;

    assign revert = cfg.revert;

    fcw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .sw_code(sw_code), .sw_wr(sw_wr),
        .div_set(div_set), .div_clr(div_clr), .arm(arm), .cancel(cancel),
        .clr_status(clr_status)
    );

    fcw_wdog #(.TICK_DIV(TICK_DIV), .HALF_W(HALF_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cancel(cancel),
        .halves(cfg.halves), .running(wd_run), .expire(expire)
    );

    fcw_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_status(clr_status),
        .sys_rst_n(sys_rst_n), .timeout_flag(wd_timeout)
    );

    fcw_sel #(.CODE_W(CODE_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .hw_code(hw_code), .sw_code(sw_code),
        .sw_wr(sw_wr), .div_set(div_set), .div_clr(div_clr),
        .expire(expire), .revert(revert), .freq_code(freq_code),
        .div_mode(div_mode)
    );
endmodule

// File: rtl/fcw_recovery_chk.sv
// Module: fcw_recovery_chk
// Assertion checker bound to fcw_recovery. A counter measures the
// reset pulse, so no parameter-deep $past is needed.
module fcw_recovery_chk #(
    parameter int PULSE_CYC = 600_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [4:0] hw_code,
    input logic [4:0] freq_code,
    input logic       div_mode,
    input logic       sys_rst_n,
    input logic       wd_timeout,
    input logic       wd_run,
    input logic       revert
);
    logic [31:0] lowcnt;

    // Count the cycles the reset output has been low.
    always_ff @(posedge clk) begin
        if (!rst_n) lowcnt <= '0;
        else if (!sys_rst_n) lowcnt <= lowcnt + 32'd1;
        else lowcnt <= '0;
    end

    assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> (lowcnt < 32'(PULSE_CYC)));

    assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (lowcnt == 32'(PULSE_CYC)));

    assert_flag_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> wd_timeout);

    assert_only_when_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> $past(wd_run));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_timeout) |-> $past(wr_en && (wr_addr == 2'd0) && wr_data[7]));

    assert_fallback_hw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_rst_n) && !$past(revert)) |-> ((freq_code == hw_code) && !div_mode));

    assert_cancel_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd0) && (wr_data[3:0] == 4'd0)) |=> !wd_run);
endmodule

bind fcw_recovery fcw_recovery_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hw_code(hw_code), .freq_code(freq_code),
    .div_mode(div_mode), .sys_rst_n(sys_rst_n), .wd_timeout(wd_timeout),
    .wd_run(wd_run), .revert(revert)
);

// File: tb/fcw_recovery_tb.sv
// Directed bench for fcw_recovery. Inputs change on the falling edge
// and outputs are sampled there too.
module fcw_recovery_tb;
    localparam int TD = 8;
    localparam int PC = 5;
    localparam logic [4:0] HW = 5'h0A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] hw_code = HW;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] freq_code;
    logic       div_mode, sys_rst_n, wd_timeout;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fcw_recovery #(.TICK_DIV(TD), .PULSE_CYC(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_code(hw_code), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .freq_code(freq_code),
        .div_mode(div_mode), .sys_rst_n(sys_rst_n), .wd_timeout(wd_timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        chk(sys_rst_n == 1'b1, "R1 rst", sys_rst_n, 1);
        chk(wd_timeout == 1'b0, "R1 flag", wd_timeout, 0);
        chk(div_mode == 1'b0, "R1 div", div_mode, 0);
        chk(freq_code == HW, "R1 code", freq_code, HW);
    endtask

    task automatic t_zero_field();
        wr(2'd1, 8'h12);
        chk(freq_code == 5'h12, "R2 sw code", freq_code, 5'h12);
        wr(2'd2, 8'h01);
        chk(div_mode == 1'b1, "R2 div on", div_mode, 1);
        for (int i = 0; i < 4*TD; i++) begin
            @(negedge clk);
            if (!sys_rst_n) chk(1'b0, "R3 no pulse", sys_rst_n, 1);
        end
        chk(wd_timeout == 1'b0, "R3 no flag", wd_timeout, 0);
        wr(2'd2, 8'h00);
        chk(div_mode == 1'b0, "R2 div off", div_mode, 0);
    endtask

    task automatic t_expire_hw();
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h15);
        chk(freq_code == 5'h15, "R2 new code", freq_code, 5'h15);
        repeat (2*TD-1) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R4 not early", sys_rst_n, 1);
        @(negedge clk);
        chk(sys_rst_n == 1'b0, "R4 expiry", sys_rst_n, 0);
        chk(wd_timeout == 1'b1, "R6 flag", wd_timeout, 1);
        chk(freq_code == HW, "R7 hw code", freq_code, HW);
        chk(div_mode == 1'b0, "R7 div off", div_mode, 0);
        repeat (PC-1) @(negedge clk);
        chk(sys_rst_n == 1'b0, "R5 still low", sys_rst_n, 0);
        @(negedge clk);
        chk(sys_rst_n == 1'b1, "R5 released", sys_rst_n, 1);
    endtask

    task automatic t_sticky();
        repeat (20) @(negedge clk);
        chk(wd_timeout == 1'b1, "R9 sticky", wd_timeout, 1);
        wr(2'd0, 8'h82);
        chk(wd_timeout == 1'b0, "R9 cleared", wd_timeout, 0);
    endtask

    task automatic t_cancel();
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h07);
        repeat (10) @(negedge clk);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 5*TD; i++) begin
            @(negedge clk);
            if (!sys_rst_n) chk(1'b0, "R10 no pulse", sys_rst_n, 1);
        end
        chk(freq_code == 5'h07, "R10 code kept", freq_code, 5'h07);
        chk(wd_timeout == 1'b0, "R10 no flag", wd_timeout, 0);
    endtask

    task automatic t_expire_sw();
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h1C);
        wr(2'd2, 8'h01);
        chk(div_mode == 1'b1, "R3 div arms", div_mode, 1);
        repeat (TD-1) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R4 div not early", sys_rst_n, 1);
        @(negedge clk);
        chk(sys_rst_n == 1'b0, "R4 div expiry", sys_rst_n, 0);
        chk(freq_code == 5'h1C, "R8 sw code", freq_code, 5'h1C);
        chk(div_mode == 1'b1, "R8 div kept", div_mode, 1);
        repeat (PC) @(negedge clk);
        wr(2'd0, 8'h80);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_restart();
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h03);
        repeat (10) @(negedge clk);
        wr(2'd1, 8'h04);
        for (int i = 0; i < 2*TD-1; i++) begin
            @(negedge clk);
            if (!sys_rst_n) chk(1'b0, "R11 early", sys_rst_n, 1);
        end
        @(negedge clk);
        chk(sys_rst_n == 1'b0, "R11 restart", sys_rst_n, 0);
        chk(freq_code == HW, "R11 hw code", freq_code, HW);
        repeat (PC) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R5 end", sys_rst_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_field();
        t_expire_hw();
        t_sticky();
        t_cancel();
        t_expire_sw();
        t_restart();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule